// File: doc/BRIEF.md
# SDRAM start-up and refresh sequencer

This block is the power-up and refresh part of a single-data-rate SDRAM controller. It leaves reset idle and drives only NOP. Software programs a refresh period and then writes a configuration word with its enable bit set. The block then puts the standard start-up series on the command pins: a precharge of all banks, a mode-register load, and a fixed number of auto-refresh commands. A fixed run of NOP cycles follows each of these commands.

After the last start-up refresh the block raises `ready`. From then on it issues one auto-refresh each time a down-counter, loaded from the period register, runs out. Clearing the enable bit sends it back to idle at once. Setting the bit again restarts the full start-up series. Data transfers and bank or row tracking are left to the rest of the controller.

Top module: `sdram_init_refresh`

## Requirements
- R1: After reset, and in every cycle that starts while the enable bit is 0, the pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), with `addr` = 0, `ba` = 0 and `ready` = 0.
- R2: A write with `wr_sel` = 0 stores the configuration register: bit 0 is the enable bit, bits [3:1] are the CAS latency, and any other bits have no effect on this block. A write with `wr_sel` = 1 stores `wr_data` as the refresh period P. Both writes take effect at the clock edge that accepts them.
- R3: The first command after an enable write is PRECHARGE (0010), with `addr` = 1<<10 (A10 high, all banks) and `ba` = 0. It appears in the second cycle after the edge that accepted the write, and T_PRE NOP cycles follow it.
- R4: Next comes LOAD MODE (0000) with `ba` = 0. On `addr`, A[2:0] = 010 (burst of 4), A3 = 0 (sequential order), A[6:4] holds the CAS latency and all higher bits are 0. T_MRS NOP cycles follow it.
- R5: N_INIT_REF AUTO REFRESH commands (0001) follow, each with `addr` = 0 and each followed by T_RFC NOP cycles. `ready` stays 0 for the whole start-up series.
- R6: `ready` becomes 1 in the cycle right after the last NOP that follows the final start-up refresh, and it stays 1 while the block remains enabled.
- R7: Once ready, the first periodic AUTO REFRESH comes P+1 cycles after the first cycle with `ready` high. Each later one comes max(P, T_RFC)+1 cycles after the previous one. Only NOP and AUTO REFRESH appear while `ready` is high.
- R8: A configuration write with bit 0 = 0 forces NOP and `ready` = 0 from the second cycle after that write, at any point in the series. A later enable write restarts from PRECHARGE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects configuration, 1 selects refresh period |
| wr_data | input | PER_W | Write data |
| cs_n | output | 1 | SDRAM chip select, active low |
| ras_n | output | 1 | SDRAM row strobe, active low |
| cas_n | output | 1 | SDRAM column strobe, active low |
| we_n | output | 1 | SDRAM write enable, active low |
| addr | output | ADDR_W | SDRAM address bus |
| ba | output | BANK_W | SDRAM bank select |
| ready | output | 1 | Start-up series complete, refresh running |

## Verification
The bench builds the block with ADDR_W=12, PER_W=12, T_PRE=2, T_MRS=3, T_RFC=5 and N_INIT_REF=8. Because the three gaps differ, a gap counter that loads the wrong constant shows up as a shifted command. The period is set to 20 in one run and to 3 in another, so both branches of the max(P, T_RFC) spacing are checked. Two different CAS latencies exercise the mode word. An abort after the precharge checks that a restart begins cleanly from the top of the series.

// File: rtl/sdram_init_refresh.sv
`timescale 1ns/1ps
module sdram_init_refresh #(
  parameter int ADDR_W     = 12,
  parameter int BANK_W     = 2,
  parameter int PER_W      = 16,
  parameter int T_PRE      = 2,
  parameter int T_MRS      = 2,
  parameter int T_RFC      = 8,
  parameter int N_INIT_REF = 8,
  parameter logic [PER_W-1:0] PER_RESET = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [PER_W-1:0]  wr_data,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              ready
);
  localparam int GAP_A   = (T_PRE > T_MRS) ? T_PRE : T_MRS;
  localparam int GAP_MAX = (GAP_A > T_RFC) ? GAP_A : T_RFC;
  localparam int WAIT_W  = $clog2(GAP_MAX + 1);
  localparam int REF_W   = $clog2(N_INIT_REF + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;

  typedef enum logic [2:0] {S_IDLE, S_PRE_W, S_MRS_W, S_REF_W, S_RUN} st_t;

  st_t               st;
  logic              en_q;
  logic [2:0]        cl_q;
  logic [PER_W-1:0]  period_q;
  logic [PER_W-1:0]  rcnt;
  logic [WAIT_W-1:0] wcnt;
  logic [REF_W-1:0]  nref;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ready_q;
  logic [ADDR_W-1:0] mode_word;

  assign mode_word = {{(ADDR_W-7){1'b0}}, cl_q, 1'b0, 3'b010};
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr  = addr_q;
  assign ba    = '0;
  assign ready = ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      cl_q     <= 3'd2;
      period_q <= PER_RESET;
    end else if (wr_en) begin
      if (wr_sel) period_q <= wr_data;
      else begin
        en_q <= wr_data[0];
        cl_q <= wr_data[3:1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cmd_q   <= C_NOP;
      addr_q  <= '0;
      ready_q <= 1'b0;
      wcnt    <= '0;
      rcnt    <= '0;
      nref    <= '0;
    end else begin
      cmd_q  <= C_NOP;
      addr_q <= '0;
      if (!en_q) begin
        st      <= S_IDLE;
        ready_q <= 1'b0;
        wcnt    <= '0;
        nref    <= '0;
      end else begin
        case (st)
          S_IDLE: begin
            cmd_q  <= C_PRE;
            addr_q <= ALL_BANKS;
            wcnt   <= WAIT_W'(T_PRE);
            nref   <= '0;
            st     <= S_PRE_W;
          end
          S_PRE_W: begin
            if (wcnt == '0) begin
              cmd_q  <= C_MRS;
              addr_q <= mode_word;
              wcnt   <= WAIT_W'(T_MRS);
              st     <= S_MRS_W;
            end else wcnt <= wcnt - 1'b1;
          end
          S_MRS_W: begin
            if (wcnt == '0) begin
              cmd_q <= C_REF;
              wcnt  <= WAIT_W'(T_RFC);
              nref  <= REF_W'(1);
              st    <= S_REF_W;
            end else wcnt <= wcnt - 1'b1;
          end
          S_REF_W: begin
            if (wcnt == '0) begin
              if (nref == REF_W'(N_INIT_REF)) begin
                ready_q <= 1'b1;
                rcnt    <= period_q;
                st      <= S_RUN;
              end else begin
                cmd_q <= C_REF;
                wcnt  <= WAIT_W'(T_RFC);
                nref  <= nref + 1'b1;
              end
            end else wcnt <= wcnt - 1'b1;
          end
          S_RUN: begin
            if (rcnt == '0 && wcnt == '0) begin
              cmd_q <= C_REF;
              rcnt  <= period_q;
              wcnt  <= WAIT_W'(T_RFC);
            end else begin
              if (rcnt != '0) rcnt <= rcnt - 1'b1;
              if (wcnt != '0) wcnt <= wcnt - 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (cmd_q == C_NOP && !ready_q)); // R1
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q == C_PRE |-> (addr_q == ALL_BANKS && !ready_q)); // R3
  AST_MODE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q == C_MRS |-> (addr_q[3:0] == 4'b0010 && addr_q[ADDR_W-1:7] == '0)); // R4
  AST_REF_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q == C_REF |=> cmd_q == C_NOP); // R5
  AST_READY_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> nref == REF_W'(N_INIT_REF)); // R6
  AST_RUN_REF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> (cmd_q == C_NOP || cmd_q == C_REF)); // R7
endmodule

// File: tb/sim_sdram_init_refresh.sv
`timescale 1ns/1ps
module sim_sdram_init_refresh;
  localparam int ADDR_W = 12, BANK_W = 2, PER_W = 12;
  localparam int T_PRE = 2, T_MRS = 3, T_RFC = 5, N_INIT_REF = 8;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, MRS = 4'b0000, REF = 4'b0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [PER_W-1:0] wr_data = '0;
  logic cs_n, ras_n, cas_n, we_n, ready;
  logic [ADDR_W-1:0] addr;
  logic [BANK_W-1:0] ba;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_init_refresh #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .PER_W(PER_W), .T_PRE(T_PRE),
    .T_MRS(T_MRS), .T_RFC(T_RFC), .N_INIT_REF(N_INIT_REF)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba),
    .ready(ready));

  function automatic logic [3:0] cmd();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [PER_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_nops(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, "nop cmd", cmd(), NOP);
      chk(req, "nop addr", addr, 0);
      chk(req, "ready low", ready, 0);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R1", "reset cmd", cmd(), NOP);
      chk("R1", "reset addr", addr, 0);
      chk("R1", "reset ba", ba, 0);
      chk("R1", "reset ready", ready, 0);
    end
  endtask

  task automatic t_init(input logic [2:0] cl, input int per);
    wr(1'b1, PER_W'(per));
    wr(1'b0, {{(PER_W-4){1'b0}}, cl, 1'b1});
    @(negedge clk);
    chk("R3", "precharge cmd", cmd(), PRE);
    chk("R3", "precharge addr", addr, 12'h400);
    chk("R3", "precharge ba", ba, 0);
    expect_nops(T_PRE, "R3");
    @(negedge clk);
    chk("R4", "load mode cmd", cmd(), MRS);
    chk("R2", "mode word cas latency", addr, {5'd0, cl, 4'b0010});
    chk("R4", "load mode ba", ba, 0);
    expect_nops(T_MRS, "R4");
    for (int k = 0; k < N_INIT_REF; k++) begin
      @(negedge clk);
      chk("R5", "init refresh cmd", cmd(), REF);
      chk("R5", "init refresh addr", addr, 0);
      chk("R5", "ready during init", ready, 0);
      expect_nops(T_RFC, "R5");
    end
    @(negedge clk);
    chk("R6", "ready raised", ready, 1);
    chk("R6", "cmd at ready", cmd(), NOP);
  endtask

  task automatic t_periodic(input int per, input int n);
    int gap;
    gap = (per > T_RFC) ? per : T_RFC;
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      chk("R7", "first wait nop", cmd(), NOP);
      chk("R6", "ready held", ready, 1);
    end
    @(negedge clk);
    chk("R7", "first periodic refresh", cmd(), REF);
    for (int j = 0; j < n; j++) begin
      for (int i = 0; i < gap; i++) begin
        @(negedge clk);
        chk("R7", "gap nop", cmd(), NOP);
      end
      @(negedge clk);
      chk("R7", "periodic refresh", cmd(), REF);
      chk("R7", "ready in run", ready, 1);
    end
  endtask

  task automatic t_disable(input int n);
    wr(1'b0, '0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R8", "disabled cmd", cmd(), NOP);
      chk("R8", "disabled ready", ready, 0);
    end
  endtask

  task automatic t_abort_midway();
    wr(1'b0, 12'h005);
    @(negedge clk);
    chk("R3", "precharge before abort", cmd(), PRE);
    t_disable(30);
  endtask

  initial begin
    #40000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_init(3'd2, 20);
    t_periodic(20, 3);
    t_disable(25);
    t_abort_midway();
    t_init(3'd3, 3);
    t_periodic(3, 4);
    t_disable(10);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule